// File: doc/BRIEF.md
# Value-Mask and Edge Trigger Detector

This block watches the sample stream of a multi-channel logic analyzer and decides, one sample at a time, whether a trigger condition holds. A valid sample is compared with the previous valid sample. There are three conditions: a level condition (selected channels must match a stored pattern), a rising-edge condition and a falling-edge condition. The trigger pulse fires only when all three hold on the same pair of samples. A fast mode replaces all of this with a single armed edge on one of the eight lowest channels.

A second function refines a coarse trigger position. When the acquisition logic flags a sample as a coarse hit, the block opens a search window of eight valid samples that starts at that sample. It reports the offset of the first sample in the window that satisfies the trigger condition. The first sample of the window is compared with the sample that came just before it. If no sample in the window matches, the block reports offset zero, which is the coarse position itself.

Top module: `edge_level_trigger`

## Requirements
- R1: Level condition: the current sample ANDed with `cfg_lvl_mask` must equal `cfg_lvl_value` in full. A value bit set outside the mask therefore makes the level condition impossible. An all-zero mask together with a zero value always passes.
- R2: Rising condition: every channel set in `cfg_rise_mask` must be 0 in the previous sample and 1 in the current sample. An all-zero mask always passes.
- R3: Falling condition: every channel set in `cfg_fall_mask` must be 1 in the previous sample and 0 in the current sample. An all-zero mask always passes.
- R4: In normal mode (`cfg_fast`=0) a sample matches only when R1, R2 and R3 all hold on the same sample pair. With all masks and the value at zero, every valid sample matches.
- R5: `trig_out` is high for exactly the one clock after a valid sample that matches. A cycle with `smp_valid`=0 raises nothing and leaves the previous-sample register unchanged. After reset, `trig_out` and `win_done` are 0.
- R6: After reset the previous sample reads as all zeros. A first valid sample with a rise-masked channel at 1 therefore counts as a rising edge.
- R7: In fast mode (`cfg_fast`=1) a sample matches only on an edge of channel `cfg_fast_sel[2:0]` (range 0 to 7). `cfg_fast_sel[3]`=1 selects a falling edge and 0 selects a rising edge. The level, rise and fall mask registers have no effect in this mode.
- R8: A valid sample with `coarse_hit`=1, taken while no window is open, becomes window sample 0. Sample 0 is compared with the valid sample before it. Only valid samples advance the window. On the first matching sample the block reports `win_found`=1 and `win_idx` set to that sample's position, from 0 to 7.
- R9: If none of the eight window samples matches, the block reports `win_found`=0 and `win_idx`=0 once the eighth sample is seen.
- R10: `coarse_hit` has no effect while a window is open. A coarse hit in the cycle that follows a report starts a new window.
- R11: `win_done` is a one-clock pulse in the cycle after the valid sample that decides the window. `win_found` and `win_idx` are valid while `win_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | 16 | Current sample, one bit per channel |
| cfg_lvl_mask | input | 16 | Channels taking part in the level condition |
| cfg_lvl_value | input | 16 | Required level on masked channels |
| cfg_rise_mask | input | 16 | Channels that must rise |
| cfg_fall_mask | input | 16 | Channels that must fall |
| cfg_fast | input | 1 | Single-edge fast mode |
| cfg_fast_sel | input | 4 | Fast edge: [2:0] channel, [3] falling select |
| coarse_hit | input | 1 | Marks the sample that opens a refine window |
| trig_out | output | 1 | One-clock trigger pulse |
| win_done | output | 1 | Refine window decided |
| win_found | output | 1 | A match was found in the window |
| win_idx | output | 3 | Offset of the first match, or 0 on a miss |

## Verification
If the previous-sample register were corrupted, for example by being loaded on an invalid cycle, edge triggers would be wrong on the very next valid sample. The bench sweeps every pair of samples over the masked channels, and it inserts invalid cycles just before an edge so that this shows up. An error in the window counter or its decision appears at the latest eight valid samples after the coarse hit, as a wrong `win_idx` or a misplaced `win_done`. For this reason each match position 0 to 7 is checked, and so are the miss case, the boundary at the window's first sample, and re-arming in the cycle after a report.

// File: rtl/elt_pkg.sv
package elt_pkg;
  localparam int FAST_CH_W = 3;  // fast edge channel field width

  typedef struct packed {
    logic                 falling;
    logic [FAST_CH_W-1:0] ch;
  } fast_sel_t;
endpackage

// File: rtl/elt_match.sv
module elt_match
  import elt_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0] cur,
  input  logic [NCH-1:0] prv,
  input  logic [NCH-1:0] lvl_mask,
  input  logic [NCH-1:0] lvl_value,
  input  logic [NCH-1:0] rise_mask,
  input  logic [NCH-1:0] fall_mask,
  input  logic           fast_en,
  input  fast_sel_t      fast_sel,
  output logic           hit
);
  logic lvl_ok, rise_ok, fall_ok, slow_hit;
  logic fcur, fprv, fast_hit;

  // R1 R2 R3: an empty mask reduces each term to a trivial truth
  always_comb begin
    lvl_ok   = ((cur & lvl_mask) == lvl_value);
    rise_ok  = ((prv & rise_mask) == '0) && ((cur & rise_mask) == rise_mask);
    fall_ok  = ((prv & fall_mask) == fall_mask) && ((cur & fall_mask) == '0);
    slow_hit = lvl_ok && rise_ok && fall_ok;  // R4
  end

  // R7: single armed edge on one low channel
  always_comb begin
    fcur     = cur[fast_sel.ch];
    fprv     = prv[fast_sel.ch];
    fast_hit = fast_sel.falling ? (fprv && !fcur) : (!fprv && fcur);
    hit      = fast_en ? fast_hit : slow_hit;
  end
endmodule

// File: rtl/elt_window.sv
module elt_window #(
  parameter int WIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             coarse_hit,
  input  logic             hit,
  output logic             done,
  output logic             found,
  output logic [$clog2(WIN)-1:0] idx
);
  localparam int IDX_W = $clog2(WIN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             found_q, found_d;
  logic             open_w, step_w;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    found_d  = 1'b0;
    open_w   = smp_valid && !active_q && coarse_hit;  // R10: ignored while open
    step_w   = smp_valid && active_q;
    if (open_w) begin
      if (hit) begin                                 // R8: match at offset 0
        done_d  = 1'b1;
        found_d = 1'b1;
        idx_d   = '0;
      end else begin
        active_d = 1'b1;
        cnt_d    = IDX_W'(1);
      end
    end else if (step_w) begin
      if (hit || (cnt_q == LAST)) begin
        done_d   = 1'b1;
        found_d  = hit;
        idx_d    = hit ? cnt_q : '0;                 // R9: miss reports 0
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
    end else begin
      done_q  <= done_d;   // R11: one-clock pulse
      found_q <= found_d;
      if (smp_valid) begin
        active_q <= active_d;
        cnt_q    <= cnt_d;
        idx_q    <= idx_d;
      end
    end
  end

  assign done  = done_q;
  assign found = found_q;
  assign idx   = idx_q;

  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !found_q) |-> (idx_q == '0));  // R9
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active_q);  // R10
  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(smp_valid));  // R11
endmodule

// File: rtl/edge_level_trigger.sv
module edge_level_trigger
  import elt_pkg::*;
#(
  parameter int NCH = 16,
  parameter int WIN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic [NCH-1:0]         smp_data,
  input  logic [NCH-1:0]         cfg_lvl_mask,
  input  logic [NCH-1:0]         cfg_lvl_value,
  input  logic [NCH-1:0]         cfg_rise_mask,
  input  logic [NCH-1:0]         cfg_fall_mask,
  input  logic                   cfg_fast,
  input  logic [FAST_CH_W:0]     cfg_fast_sel,
  input  logic                   coarse_hit,
  output logic                   trig_out,
  output logic                   win_done,
  output logic                   win_found,
  output logic [$clog2(WIN)-1:0] win_idx
);
  logic [NCH-1:0] prev_q, prev_d;
  logic           trig_q, trig_d;
  logic           hit;

  elt_match #(.NCH(NCH)) u_match (
    .cur       (smp_data),
    .prv       (prev_q),
    .lvl_mask  (cfg_lvl_mask),
    .lvl_value (cfg_lvl_value),
    .rise_mask (cfg_rise_mask),
    .fall_mask (cfg_fall_mask),
    .fast_en   (cfg_fast),
    .fast_sel  (fast_sel_t'(cfg_fast_sel)),
    .hit       (hit)
  );

  elt_window #(.WIN(WIN)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .coarse_hit (coarse_hit),
    .hit        (hit),
    .done       (win_done),
    .found      (win_found),
    .idx        (win_idx)
  );

  // R5 R6: previous sample loads on valid samples only, zero after reset
  always_comb begin
    prev_d = smp_valid ? smp_data : prev_q;
    trig_d = smp_valid && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
      if (smp_valid) prev_q <= prev_d;
    end
  end

  assign trig_out = trig_q;

  AST_TRIG_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> $past(smp_valid));  // R5
  AST_FOUND_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && win_found) |-> trig_q);  // R8
  AST_PREV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> $stable(prev_q));  // R5
endmodule

// File: tb/edge_level_trigger_tb.sv
module edge_level_trigger_tb;
  localparam int NCH = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic           smp_valid;
  logic [NCH-1:0] smp_data;
  logic [NCH-1:0] lm, lv, rm, fm;
  logic           fast;
  logic [3:0]     fsel;
  logic           coarse;
  logic           trig_out, win_done, win_found;
  logic [2:0]     win_idx;

  edge_level_trigger u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_valid     (smp_valid),
    .smp_data      (smp_data),
    .cfg_lvl_mask  (lm),
    .cfg_lvl_value (lv),
    .cfg_rise_mask (rm),
    .cfg_fall_mask (fm),
    .cfg_fast      (fast),
    .cfg_fast_sel  (fsel),
    .coarse_hit    (coarse),
    .trig_out      (trig_out),
    .win_done      (win_done),
    .win_found     (win_found),
    .win_idx       (win_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [NCH-1:0] m_prev;
  bit m_act;
  int m_cnt;

  function automatic bit ref_hit(input logic [NCH-1:0] c, input logic [NCH-1:0] p);
    int ch;
    if (fast) begin
      ch = int'(fsel[2:0]);
      return fsel[3] ? (p[ch] && !c[ch]) : (!p[ch] && c[ch]);
    end
    return ((c & lm) == lv) && ((p & rm) == 0) && ((c & rm) == rm) &&
           ((p & fm) == fm) && ((c & fm) == 0);
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %b expected %b (trig,done,found,idx)", tag, got, exp);
    end
  endtask

  task automatic step(input bit v, input logic [NCH-1:0] d, input bit co, input string tag);
    bit h, e_done, e_found;
    logic [2:0] e_idx;
    logic [5:0] got;
    smp_valid = v; smp_data = d; coarse = co;
    h = v && ref_hit(d, m_prev);
    e_done = 0; e_found = 0; e_idx = 0;
    if (v) begin
      if (!m_act && co) begin
        if (h) begin e_done = 1; e_found = 1; end
        else begin m_act = 1; m_cnt = 1; end
      end else if (m_act) begin
        if (h || m_cnt == 7) begin
          e_done = 1; e_found = h; e_idx = h ? 3'(m_cnt) : 3'd0; m_act = 0;
        end else m_cnt++;
      end
      m_prev = d;
    end
    @(posedge clk); #1;
    got = {trig_out, win_done, win_done ? win_found : 1'b0, win_done ? win_idx : 3'd0};
    check(tag, got, {h, e_done, e_found, e_idx});
  endtask

  task automatic cfg(input logic [NCH-1:0] a, input logic [NCH-1:0] b,
                     input logic [NCH-1:0] c, input logic [NCH-1:0] d);
    lm = a; lv = b; rm = c; fm = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_data = '0; coarse = 0; fast = 0; fsel = '0;
    cfg('0, '0, '0, '0);
    m_prev = '0; m_act = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check("R5 reset", {trig_out, win_done, 4'b0}, 6'b0);

    // R6: previous sample is zero after reset
    cfg('0, '0, 16'h0001, '0);
    step(1, 16'h0001, 0, "R6");

    // R1: level sweep, mask 0x000A, all values and samples on low nibble
    for (int v = 0; v < 16; v++) begin
      cfg(16'h000A, NCH'(v), '0, '0);
      for (int s = 0; s < 16; s++) step(1, NCH'(s), 0, "R1");
    end

    // R2: rising pairs over channels 0 and 2
    cfg('0, '0, 16'h0005, '0);
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 16; c++) begin
        step(1, NCH'(p), 0, "R2"); step(1, NCH'(c), 0, "R2");
      end

    // R3: falling pairs over channels 1 and 2
    cfg('0, '0, '0, 16'h0006);
    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 16; c++) begin
        step(1, NCH'(p), 0, "R3"); step(1, NCH'(c), 0, "R3");
      end

    // R4: combined level on ch8, rise ch0, fall ch1
    cfg(16'h0100, 16'h0100, 16'h0001, 16'h0002);
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++) begin
        step(1, {7'd0, p[2], 6'd0, p[1:0]}, 0, "R4");
        step(1, {7'd0, c[2], 6'd0, c[1:0]}, 0, "R4");
      end
    cfg('0, '0, '0, '0);
    step(1, 16'hBEEF, 0, "R4"); step(1, 16'hBEEF, 0, "R4"); step(1, 16'h0000, 0, "R4");

    // R5: invalid cycles neither fire nor load the previous sample
    cfg(16'h00FF, 16'h0012, '0, '0);
    step(0, 16'h0012, 0, "R5");
    cfg('0, '0, 16'h0080, '0);
    step(1, 16'h0000, 0, "R5");
    step(0, 16'h0080, 0, "R5");
    step(1, 16'h0080, 0, "R5");
    step(1, 16'h0080, 0, "R5");

    // R7: fast mode, all selections, masks set to conflict
    fast = 1;
    cfg(16'hFFFF, 16'h1234, 16'hFFFF, 16'hFFFF);
    for (int s = 0; s < 16; s++) begin
      fsel = 4'(s);
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 2; c++) begin
          step(1, (16'h5A5A & ~(16'h1 << s[2:0])) | (NCH'(p) << s[2:0]), 0, "R7");
          step(1, (16'hA5A5 & ~(16'h1 << s[2:0])) | (NCH'(c) << s[2:0]), 0, "R7");
        end
    end
    fast = 0;

    // R8: first match at every offset, with gaps in one case
    cfg('0, '0, 16'h0010, '0);
    for (int pos = 0; pos < 8; pos++) begin
      step(1, 16'h0000, 0, "R8");
      for (int k = 0; k < 8; k++) begin
        if (pos == 5) step(0, 16'h0010, 0, "R8");
        step(1, (k >= pos) ? 16'h0010 : 16'h0000, k == 0, "R8");
      end
    end
    // R8 boundary: window sample 0 compared with the sample before it
    step(1, 16'h0010, 0, "R8");
    step(1, 16'h0010, 1, "R8");
    for (int k = 1; k < 8; k++) step(1, 16'h0010, 0, "R8");

    // R9: no match in the window
    step(1, 16'h0000, 1, "R9");
    for (int k = 1; k < 8; k++) step(1, 16'h0000, 0, "R9");
    step(1, 16'h0000, 0, "R9");

    // R10: coarse ignored while open, then restart right after report
    step(1, 16'h0000, 1, "R10");
    step(1, 16'h0000, 1, "R10");
    step(1, 16'h0000, 1, "R10");
    step(1, 16'h0010, 1, "R10");
    step(1, 16'h0000, 1, "R10");
    for (int k = 1; k < 9; k++) step(1, 16'h0000, 0, "R10");

    // R11: done is a single pulse, then low with idle input
    step(1, 16'h0000, 1, "R11");
    step(1, 16'h0010, 0, "R11");
    step(0, 16'h0000, 0, "R11");
    step(0, 16'h0000, 0, "R11");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule